// File: doc/BRIEF.md
# Page Private/Shared Classifier

This block decides, page by page, whether a memory page belongs to one core or is used by several. Each access presents a requesting core and a page number. The block returns the page's class and whether this access changed it. Private pages stay out of directory tracking. Only a page that is shared needs coherence bookkeeping downstream.

A page that the table does not hold is entered as private to the core that touches it. When a different core later touches that private page, the page becomes shared and stays shared. At that moment the block raises a recovery request that names the page, the core that owned it, and whether the owner's cached lines of that page should be flushed or updated. New accesses stall until the recovery agent acknowledges the request. The table is small and fully associative. When it is full, entries are replaced round-robin. An evicted page loses its history and comes back as private on its next access.

Top module: `page_share_tracker`

## Requirements
- R1: After reset the table holds no pages, res_valid_o and rec_req_o are 0, and acc_ready_o is 1.
- R2: An accepted access to a page not in the table enters it as private, owned by acc_core_i. It reports res_shared_o=0 and res_trans_o=0, and raises no recovery request.
- R3: An accepted access by the owner of a private page reports private with no transition and no recovery request.
- R4: An accepted access by another core to a private page marks it shared and reports res_shared_o=1 and res_trans_o=1. In the same cycle it raises rec_req_o, with rec_page_o equal to the page and rec_owner_o equal to the former owner.
- R5: Any accepted access to a shared page reports res_shared_o=1 and res_trans_o=0 and raises no request. A shared page never returns to private while it stays in the table.
- R6: rec_mode_o carries the value of mode_i at the accepted access that caused the transition (0 = flush the owner's lines, 1 = update them).
- R7: While rec_req_o is 1, acc_ready_o is 0, and any access presented is ignored. It produces no result and leaves the table unchanged.
- R8: rec_req_o, rec_page_o, rec_owner_o and rec_mode_o hold until rec_ack_i is sampled high. rec_req_o is 0 and acc_ready_o is 1 in the following cycle.
- R9: With all ENTRIES slots filled, each new page replaces slots in round-robin order starting from slot 0. The first-entered page is evicted first, and its next access re-enters it as private with no transition.
- R10: res_valid_o is 1 for exactly one cycle, the cycle after each accepted access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| acc_valid_i | input | 1 | Access present |
| acc_ready_o | output | 1 | Access can be accepted |
| acc_core_i | input | CORE_W | Requesting core |
| acc_page_i | input | PAGE_W | Page number |
| mode_i | input | 1 | Recovery kind for a transition: 0 flush, 1 update |
| res_valid_o | output | 1 | Result of the previous accepted access |
| res_shared_o | output | 1 | Page is shared |
| res_trans_o | output | 1 | Access made the page shared |
| rec_req_o | output | 1 | Recovery request pending |
| rec_page_o | output | PAGE_W | Page to recover |
| rec_owner_o | output | CORE_W | Former owner |
| rec_mode_o | output | 1 | Recovery kind |
| rec_ack_i | input | 1 | Recovery done |

## Verification
Each accepted access is driven on a falling edge. Its result, and any recovery request it raises, is due after exactly one rising edge, so the bench samples both on the next falling edge. res_valid_o must be low again one cycle later. Holding of a pending request is checked on every falling edge before the acknowledgement. Release of the request is checked on the falling edge after the edge that samples rec_ack_i. An access presented during the stall is checked for the absence of a result one cycle later, and for its lack of effect through a later access to the same page.

// File: rtl/pst_pkg.sv
package pst_pkg;
  typedef enum logic {
    REC_FLUSH  = 1'b0,
    REC_UPDATE = 1'b1
  } rec_mode_e;
endpackage

// File: rtl/pst_lookup.sv
module pst_lookup #(
  parameter int ENTRIES = 16,
  parameter int PAGE_W  = 20,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0]             valid_i,
  input  logic [ENTRIES-1:0][PAGE_W-1:0] tag_i,
  input  logic [PAGE_W-1:0]              page_i,
  output logic [ENTRIES-1:0]             match_o,
  output logic                           hit_o,
  output logic [IDX_W-1:0]               idx_o
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_o[g] = valid_i[g] && (tag_i[g] == page_i);
  end

  assign hit_o = |match_o;

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match_o[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/pst_table.sv
module pst_table #(
  parameter int ENTRIES = 16,
  parameter int PAGE_W  = 20,
  parameter int CORE_W  = 3,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           alloc_i,
  input  logic                           share_i,
  input  logic [IDX_W-1:0]               hit_idx_i,
  input  logic [PAGE_W-1:0]              page_i,
  input  logic [CORE_W-1:0]              core_i,
  output logic [ENTRIES-1:0]             valid_o,
  output logic [ENTRIES-1:0][PAGE_W-1:0] tag_o,
  output logic [ENTRIES-1:0]             shared_o,
  output logic [ENTRIES-1:0][CORE_W-1:0] owner_o
);
  logic [IDX_W-1:0] rr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rr_q     <= '0;
      valid_o  <= '0;
      tag_o    <= '0;
      shared_o <= '0;
      owner_o  <= '0;
    end else if (alloc_i) begin
      // new page replaces the round-robin victim as private
      valid_o[rr_q]  <= 1'b1;
      tag_o[rr_q]    <= page_i;
      shared_o[rr_q] <= 1'b0;
      owner_o[rr_q]  <= core_i;
      rr_q           <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end else if (share_i) begin
      shared_o[hit_idx_i] <= 1'b1;
    end
  end

  AST_SHARE_FROM_PRIVATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    share_i |-> valid_o[hit_idx_i] && !shared_o[hit_idx_i] && owner_o[hit_idx_i] != core_i); // R4
  AST_SHARED_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !alloc_i && shared_o[hit_idx_i] |=> shared_o[$past(hit_idx_i)]); // R5
endmodule

// File: rtl/pst_recovery.sv
module pst_recovery #(
  parameter int PAGE_W = 20,
  parameter int CORE_W = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [PAGE_W-1:0]   page_i,
  input  logic [CORE_W-1:0]   owner_i,
  input  pst_pkg::rec_mode_e  mode_i,
  input  logic                ack_i,
  output logic                req_o,
  output logic [PAGE_W-1:0]   page_o,
  output logic [CORE_W-1:0]   owner_o,
  output pst_pkg::rec_mode_e  mode_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o   <= 1'b0;
      page_o  <= '0;
      owner_o <= '0;
      mode_o  <= pst_pkg::REC_FLUSH;
    end else if (start_i) begin
      req_o   <= 1'b1;
      page_o  <= page_i;
      owner_o <= owner_i;
      mode_o  <= mode_i;
    end else if (ack_i) begin
      req_o <= 1'b0;
    end
  end

  AST_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !req_o); // R7
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !ack_i |=> req_o && $stable(page_o) && $stable(owner_o) && $stable(mode_o)); // R8
  AST_REQ_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && ack_i |=> !req_o); // R8
endmodule

// File: rtl/page_share_tracker.sv
module page_share_tracker #(
  parameter int NUM_CORES = 8,
  parameter int PAGE_W    = 20,
  parameter int ENTRIES   = 16,
  localparam int CORE_W   = $clog2(NUM_CORES),
  localparam int IDX_W    = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_valid_i,
  output logic              acc_ready_o,
  input  logic [CORE_W-1:0] acc_core_i,
  input  logic [PAGE_W-1:0] acc_page_i,
  input  logic              mode_i,
  output logic              res_valid_o,
  output logic              res_shared_o,
  output logic              res_trans_o,
  output logic              rec_req_o,
  output logic [PAGE_W-1:0] rec_page_o,
  output logic [CORE_W-1:0] rec_owner_o,
  output logic              rec_mode_o,
  input  logic              rec_ack_i
);
  import pst_pkg::*;

  logic [ENTRIES-1:0]             valid;
  logic [ENTRIES-1:0][PAGE_W-1:0] tag;
  logic [ENTRIES-1:0]             shared;
  logic [ENTRIES-1:0][CORE_W-1:0] owner;
  logic [ENTRIES-1:0]             match;
  logic                           hit;
  logic [IDX_W-1:0]               hit_idx;
  logic                           accept, alloc, trans, hit_shared;
  logic [CORE_W-1:0]              hit_owner;
  rec_mode_e                      rec_mode;

  assign acc_ready_o = !rec_req_o;
  assign accept      = acc_valid_i && acc_ready_o;
  assign hit_shared  = shared[hit_idx];
  assign hit_owner   = owner[hit_idx];
  assign alloc       = accept && !hit;
  assign trans       = accept && hit && !hit_shared && (hit_owner != acc_core_i);

  pst_lookup #(.ENTRIES(ENTRIES), .PAGE_W(PAGE_W)) u_lookup (
    .valid_i (valid),
    .tag_i   (tag),
    .page_i  (acc_page_i),
    .match_o (match),
    .hit_o   (hit),
    .idx_o   (hit_idx)
  );

  pst_table #(.ENTRIES(ENTRIES), .PAGE_W(PAGE_W), .CORE_W(CORE_W)) u_table (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .alloc_i   (alloc),
    .share_i   (trans),
    .hit_idx_i (hit_idx),
    .page_i    (acc_page_i),
    .core_i    (acc_core_i),
    .valid_o   (valid),
    .tag_o     (tag),
    .shared_o  (shared),
    .owner_o   (owner)
  );

  pst_recovery #(.PAGE_W(PAGE_W), .CORE_W(CORE_W)) u_rec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (trans),
    .page_i  (acc_page_i),
    .owner_i (hit_owner),
    .mode_i  (rec_mode_e'(mode_i)),
    .ack_i   (rec_ack_i),
    .req_o   (rec_req_o),
    .page_o  (rec_page_o),
    .owner_o (rec_owner_o),
    .mode_o  (rec_mode)
  );
  assign rec_mode_o = rec_mode;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o  <= 1'b0;
      res_shared_o <= 1'b0;
      res_trans_o  <= 1'b0;
    end else begin
      res_valid_o <= accept;
      if (accept) begin
        res_shared_o <= hit && (hit_shared || trans);
        res_trans_o  <= trans;
      end
    end
  end

  AST_UNIQUE_TAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match)); // R2
  AST_TRANS_RAISES_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && res_trans_o |-> rec_req_o); // R4
  AST_PRIVATE_NO_TRANS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && !res_shared_o |-> !res_trans_o); // R3
  AST_STALL_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_req_o && acc_valid_i |=> !res_valid_o); // R7
  AST_RES_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && !(acc_valid_i && acc_ready_o) |=> !res_valid_o); // R10
endmodule

// File: tb/page_share_tracker_test.sv
`timescale 1ns/1ps
module page_share_tracker_test;
  localparam int NC = 8, PW = 20, NE = 16, CW = $clog2(NC);

  logic clk = 0, rst_n = 0;
  logic acc_valid = 0, mode = 0, rec_ack = 0;
  logic [CW-1:0] acc_core = '0;
  logic [PW-1:0] acc_page = '0;
  logic acc_ready, res_valid, res_shared, res_trans, rec_req, rec_mode;
  logic [PW-1:0] rec_page;
  logic [CW-1:0] rec_owner;

  always #2.5 clk = ~clk;

  page_share_tracker #(.NUM_CORES(NC), .PAGE_W(PW), .ENTRIES(NE)) uut (
    .clk_i(clk), .rst_ni(rst_n), .acc_valid_i(acc_valid), .acc_ready_o(acc_ready),
    .acc_core_i(acc_core), .acc_page_i(acc_page), .mode_i(mode),
    .res_valid_o(res_valid), .res_shared_o(res_shared), .res_trans_o(res_trans),
    .rec_req_o(rec_req), .rec_page_o(rec_page), .rec_owner_o(rec_owner),
    .rec_mode_o(rec_mode), .rec_ack_i(rec_ack));

  int checks = 0, fails = 0;

  // reference table
  bit m_v[NE];
  int m_tag[NE];
  bit m_sh[NE];
  int m_own[NE];
  int m_rr = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  function automatic int find(int pg);
    for (int i = 0; i < NE; i++) if (m_v[i] && m_tag[i] == pg) return i;
    return -1;
  endfunction

  // returns expected transition through last_tr
  bit last_tr;
  task automatic do_access(int core, int pg, bit md, bit do_stall, int s_core, int s_pg);
    int idx = find(pg);
    bit e_sh, e_tr;
    int e_own = 0;
    string tag;
    if (idx < 0) begin
      e_sh = 0; e_tr = 0; tag = "R2";
      m_v[m_rr] = 1; m_tag[m_rr] = pg; m_sh[m_rr] = 0; m_own[m_rr] = core;
      m_rr = (m_rr + 1) % NE;
    end else if (m_sh[idx]) begin
      e_sh = 1; e_tr = 0; tag = "R5";
    end else if (m_own[idx] == core) begin
      e_sh = 0; e_tr = 0; tag = "R3";
    end else begin
      e_sh = 1; e_tr = 1; tag = "R4"; e_own = m_own[idx]; m_sh[idx] = 1;
    end
    last_tr = e_tr;
    chk(acc_ready == 1, "R8", acc_ready, 1);
    acc_valid = 1; acc_core = CW'(core); acc_page = PW'(pg); mode = md;
    @(negedge clk);
    acc_valid = 0;
    chk(res_valid == 1, "R10", res_valid, 1);
    chk(res_shared == e_sh, tag, res_shared, e_sh);
    chk(res_trans == e_tr, tag, res_trans, e_tr);
    chk(rec_req == e_tr, tag, rec_req, e_tr);
    if (e_tr) begin
      chk(rec_page == PW'(pg), "R4", rec_page, pg);
      chk(rec_owner == CW'(e_own), "R4", rec_owner, e_own);
      chk(rec_mode == md, "R6", rec_mode, md);
      chk(acc_ready == 0, "R7", acc_ready, 0);
      for (int w = 0; w < int'($urandom % 3); w++) begin
        @(negedge clk);
        chk(rec_req == 1 && rec_page == PW'(pg), "R8", rec_req, 1);
        chk(res_valid == 0, "R10", res_valid, 0);
      end
      if (do_stall) begin
        acc_valid = 1; acc_core = CW'(s_core); acc_page = PW'(s_pg); mode = ~md;
        @(negedge clk);
        acc_valid = 0;
        chk(res_valid == 0, "R7", res_valid, 0);
        chk(rec_req == 1 && rec_mode == md, "R7", rec_mode, md);
      end
      rec_ack = 1;
      @(negedge clk);
      rec_ack = 0;
      chk(rec_req == 0, "R8", rec_req, 0);
      chk(acc_ready == 1, "R8", acc_ready, 1);
      chk(res_valid == 0, "R10", res_valid, 0);
    end else begin
      @(negedge clk);
      chk(res_valid == 0, "R10", res_valid, 0);
    end
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual 0 expected 1");
    summary();
  end

  initial begin
    void'($urandom(32'h0000_5eed));
    repeat (3) @(negedge clk);
    chk(res_valid == 0, "R1", res_valid, 0);
    chk(rec_req == 0, "R1", rec_req, 0);
    rst_n = 1;
    @(negedge clk);
    chk(acc_ready == 1, "R1", acc_ready, 1);
    chk(res_valid == 0 && rec_req == 0, "R1", rec_req, 0);

    // basic class walk
    do_access(1, 200, 0, 0, 0, 0);   // R2
    do_access(1, 200, 0, 0, 0, 0);   // R3
    do_access(3, 200, 1, 0, 0, 0);   // R4, R6 update
    chk(last_tr == 1, "R4", last_tr, 1);
    do_access(1, 200, 0, 0, 0, 0);   // R5
    do_access(3, 200, 0, 0, 0, 0);   // R5
    do_access(0, 201, 0, 0, 0, 0);
    do_access(5, 201, 0, 0, 0, 0);   // R6 flush

    // R7: access during stall is dropped
    do_access(0, 300, 0, 0, 0, 0);
    do_access(1, 300, 1, 1, 2, 301);
    do_access(3, 301, 0, 0, 0, 0);
    chk(res_shared == 0 && last_tr == 0, "R7", res_trans, 0);
    do_access(2, 300, 0, 1, 2, 300); // shared, no stall path

    // R9: round-robin eviction, slot order from m_rr
    for (int k = 0; k < NE; k++) do_access(0, 1000 + k, 0, 0, 0, 0);
    do_access(4, 1000 + NE, 0, 0, 0, 0); // evicts 1000
    do_access(2, 1000, 0, 0, 0, 0);
    chk(last_tr == 0 && res_shared == 0, "R9", res_shared, 0);
    do_access(4, 1001 + NE, 0, 0, 0, 0);

    // random mix over a small page pool to force sharing and eviction
    for (int n = 0; n < 600; n++) begin
      do_access(int'($urandom % 4), 5000 + int'($urandom % 22), bit'($urandom % 2),
                bit'($urandom % 2), int'($urandom % 4), 5000 + int'($urandom % 22));
    end
    summary();
  end
endmodule